// File: doc/BRIEF.md
# Upset Classifying Storage Tester

This block drives an array of storage cells inside a device under test and watches a set of its unclocked logic outputs, sorting every fault it sees into one of three kinds. Each cell is loaded through a per-cell write strobe, which works as an enable. The tester alone decides when a cell may change state. Afterwards it leaves the data input at a chosen level, so the data input and the stored value can sit in any of the four combinations. The cells are then read back over and over. A cell that reads wrong is written again and read again. If the second read is right, the fault was a bit flip in the cell. If it is still wrong, the fault lies in the configuration or routing.

A single sequencer walks the cells through its states. It waits in IDLE until `run` is high and then latches the pattern. WRITE loads every cell in one cycle. HOLD waits `HOLD_CYC` cycles. READ samples one cell and COMPARE checks that sample. A match moves on to READ for the next cell. A mismatch leads to REWRITE, which strobes only that cell, then RECHECK, which samples it again, then LOG, which posts the event. After the last cell the sequencer goes back to HOLD for another pass, or to IDLE if `run` has dropped.

Each logic lane is compared with its expected level on every clock. A lane that stays wrong for the programmed number of samples is logged once as a configuration upset. A shorter wrong run is logged as transient when the lane recovers. Every event bumps a saturating counter for its type and places a record in a 16-deep FIFO.

Top module: `upset_tester`

## Requirements
- R1: The WRITE cycle drives every cell's data input to pattern bit 0 (`pat_sel[0]`, the value to store) with all strobes high. From then on, data inputs carry pattern bit 1 (`pat_sel[1]`) and strobes stay low, except for a single strobe during a rewrite. The pattern is latched when leaving IDLE.
- R2: A cell that reads back different from pattern bit 0, and reads correct after being rewritten, is logged with type code 2'b00 (storage upset). It increments `cnt_storage` and is left holding the right value.
- R3: A cell that still reads wrong after its rewrite is logged with type code 2'b01 (configuration upset) and increments `cnt_config`.
- R4: A logic lane (`logic_obs[i]` differing from `logic_ref[i]`) that is wrong for fewer consecutive samples than the limit and then recovers is logged on recovery with type code 2'b10 and increments `cnt_transient`.
- R5: A lane wrong for `persist_lim` consecutive samples is logged once with type 2'b01 at the sample that reaches the limit; its later recovery logs nothing. A limit of 0 acts as 1, and the default limit in use is 8.
- R6: Records are `{src, type[1:0], idx[2:0]}` (src 0 = cell, 1 = logic lane). The FIFO holds 16 records in arrival order and shows its head on `ev_data` while `ev_valid` is high. `ev_pop` removes the head. A sequencer record wins over lane records in the same cycle, and among lanes the lowest index wins.
- R7: `ev_overflow` is set, and stays set until `cnt_clr`, when a record is lost because the FIFO is full or a lane raises a new event while its previous one is still waiting.
- R8: The three counters are 16-bit, count every detection even when its record is lost, saturate at 65535, and clear to zero one cycle after `cnt_clr`.
- R9: After reset, all counters are zero, the FIFO is empty and no strobe is high. With `run` low at the end of a pass, the sequencer stays idle and does not scan the cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Start and keep cell scanning |
| pat_sel | input | 2 | Bit 1 = data-input level while holding, bit 0 = stored value |
| persist_lim | input | 8 | Consecutive wrong samples that make a lane error persistent |
| cnt_clr | input | 1 | Synchronous clear of counters and overflow flag |
| cell_q | input | 8 | Stored values read from the cells |
| cell_d | output | 8 | Data inputs driven to the cells |
| cell_strobe | output | 8 | Per-cell write enable |
| logic_obs | input | 4 | Observed unclocked logic outputs |
| logic_ref | input | 4 | Expected levels of those outputs |
| ev_pop | input | 1 | Remove the head record |
| ev_valid | output | 1 | FIFO holds a record |
| ev_data | output | 6 | Head record |
| ev_overflow | output | 1 | Sticky record-lost flag |
| cnt_storage | output | 16 | Storage upset count |
| cnt_config | output | 16 | Configuration upset count |
| cnt_transient | output | 16 | Transient error count |

## Verification
The hardest case to reach is a cell that stays wrong across its own rewrite. A correctly modelled flip-flop always takes the rewrite. The bench model therefore holds a per-cell stuck-at override that hides the stored bit from `cell_q`, sets it while the sequencer is holding, and releases it once the configuration record shows up. Storage upsets come from a one-edge flip request in the same model. Persistent versus transient lane errors are produced by holding a lane wrong for a set number of cycles on each side of the limit. Counter saturation is reached by toggling all four lanes together for tens of thousands of cycles.

// File: rtl/upset_pkg.sv
`timescale 1ns/1ps
package upset_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_WRITE,
        SQ_HOLD,
        SQ_READ,
        SQ_COMPARE,
        SQ_REWRITE,
        SQ_RECHECK,
        SQ_LOG
    } seq_state_t;

    typedef enum logic [1:0] {
        EV_STO = 2'b00,
        EV_CFG = 2'b01,
        EV_TRN = 2'b10
    } ev_type_t;

endpackage

// File: rtl/cell_seq.sv
`timescale 1ns/1ps
module cell_seq
    import upset_pkg::*;
#(
    parameter int NCELL    = 8,
    parameter int HOLD_CYC = 32,
    parameter int CW       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       pat_sel,
    input  logic [NCELL-1:0] cell_q,
    output logic [NCELL-1:0] cell_d,
    output logic [NCELL-1:0] cell_strobe,
    output logic             log_push,
    output ev_type_t         log_type,
    output logic [CW-1:0]    log_idx
);

    localparam int HW   = $clog2(HOLD_CYC + 1);
    localparam int LAST = NCELL - 1;

    seq_state_t    state_q, state_d;
    logic [CW-1:0] idx_q;
    logic [HW-1:0] hold_q;
    logic [1:0]    pat_q;
    logic          samp_q;
    logic          fixed_q;
    logic          last_cell;
    logic          cur;

    assign last_cell = (idx_q == CW'(LAST));
    assign cur       = cell_q[idx_q];

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:    if (run) state_d = SQ_WRITE;
            SQ_WRITE:   state_d = SQ_HOLD;
            SQ_HOLD:    if (hold_q == HW'(HOLD_CYC - 1)) state_d = SQ_READ;
            SQ_READ:    state_d = SQ_COMPARE;
            SQ_COMPARE: begin
                if (samp_q != pat_q[0])  state_d = SQ_REWRITE;
                else if (!last_cell)     state_d = SQ_READ;
                else                     state_d = run ? SQ_HOLD : SQ_IDLE;
            end
            SQ_REWRITE: state_d = SQ_RECHECK;
            SQ_RECHECK: state_d = SQ_LOG;
            SQ_LOG: begin
                if (!last_cell) state_d = SQ_READ;
                else            state_d = run ? SQ_HOLD : SQ_IDLE;
            end
            default:    state_d = SQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // sequencer datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            hold_q  <= '0;
            pat_q   <= 2'b00;
            samp_q  <= 1'b0;
            fixed_q <= 1'b0;
        end else begin
            // R1: pattern captured on leaving IDLE
            if (state_q == SQ_IDLE && run) pat_q <= pat_sel;
            hold_q <= (state_q == SQ_HOLD) ? hold_q + 1'b1 : '0;
            if (state_d == SQ_HOLD || state_d == SQ_IDLE)
                idx_q <= '0;
            else if ((state_q == SQ_COMPARE || state_q == SQ_LOG) && state_d == SQ_READ)
                idx_q <= idx_q + 1'b1;
            if (state_q == SQ_READ)    samp_q  <= cur;
            if (state_q == SQ_RECHECK) fixed_q <= (cur == pat_q[0]);
        end
    end

    // outputs
    always_comb begin
        cell_d      = '0;
        cell_strobe = '0;
        log_push    = 1'b0;
        log_type    = EV_STO;
        log_idx     = idx_q;
        unique case (state_q)
            SQ_IDLE: ;
            SQ_WRITE: begin
                cell_d      = {NCELL{pat_q[0]}};
                cell_strobe = '1;
            end
            SQ_REWRITE: begin
                cell_d             = {NCELL{pat_q[1]}};
                cell_d[idx_q]      = pat_q[0];
                cell_strobe[idx_q] = 1'b1;
            end
            SQ_LOG: begin
                cell_d   = {NCELL{pat_q[1]}};
                log_push = 1'b1;
                // R2 / R3: outcome of the recheck selects the type
                log_type = fixed_q ? EV_STO : EV_CFG;
            end
            SQ_HOLD, SQ_READ, SQ_COMPARE, SQ_RECHECK: cell_d = {NCELL{pat_q[1]}};
            default: ;
        endcase
    end

endmodule

// File: rtl/logic_watch.sv
`timescale 1ns/1ps
module logic_watch
    import upset_pkg::*;
#(
    parameter int LIMW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            obs,
    input  logic            expv,
    input  logic [LIMW-1:0] lim,
    input  logic            grant,
    output logic            pend,
    output ev_type_t        ptype,
    output logic            det_cfg,
    output logic            det_trn,
    output logic            lost
);

    logic [LIMW-1:0] run_q;
    logic            persist_q;
    logic            bad;
    logic [LIMW:0]   lim_eff;
    logic            new_ev;
    ev_type_t        new_ty;

    assign bad     = obs ^ expv;
    assign lim_eff = (lim == '0) ? (LIMW+1)'(1) : {1'b0, lim};

    always_comb begin
        new_ev = 1'b0;
        new_ty = EV_TRN;
        if (bad && !persist_q && (({1'b0, run_q} + 1'b1) >= lim_eff)) begin
            new_ev = 1'b1;   // R5: limit reached
            new_ty = EV_CFG;
        end else if (!bad && !persist_q && run_q != '0) begin
            new_ev = 1'b1;   // R4: recovered before the limit
            new_ty = EV_TRN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q     <= '0;
            persist_q <= 1'b0;
            pend      <= 1'b0;
            ptype     <= EV_TRN;
            det_cfg   <= 1'b0;
            det_trn   <= 1'b0;
            lost      <= 1'b0;
        end else begin
            if (bad) begin
                if (!persist_q) run_q <= run_q + 1'b1;
                if (new_ev)     persist_q <= 1'b1;
            end else begin
                run_q     <= '0;
                persist_q <= 1'b0;
            end
            det_cfg <= new_ev && (new_ty == EV_CFG);
            det_trn <= new_ev && (new_ty == EV_TRN);
            lost    <= 1'b0;
            if (new_ev) begin
                if (pend && !grant) lost <= 1'b1;   // R7
                else begin
                    pend  <= 1'b1;
                    ptype <= new_ty;
                end
            end else if (grant) begin
                pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/event_fifo.sv
`timescale 1ns/1ps
module event_fifo #(
    parameter int W     = 6,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         valid,
    output logic         full
);

    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;
    logic         empty;

    assign empty = (wp == rp);
    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign valid = !empty;
    assign dout  = mem[rp[AW-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push && !full) wp <= wp + 1'b1;
            if (pop && !empty) rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) mem[wp[AW-1:0]] <= din;
    end

endmodule

// File: rtl/upset_tester.sv
`timescale 1ns/1ps
module upset_tester
    import upset_pkg::*;
#(
    parameter int NCELL      = 8,
    parameter int NLANE      = 4,
    parameter int HOLD_CYC   = 32,
    parameter int FIFO_DEPTH = 16,
    parameter int CNTW       = 16,
    parameter int LIMW       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       pat_sel,
    input  logic [LIMW-1:0]  persist_lim,
    input  logic             cnt_clr,
    input  logic [NCELL-1:0] cell_q,
    output logic [NCELL-1:0] cell_d,
    output logic [NCELL-1:0] cell_strobe,
    input  logic [NLANE-1:0] logic_obs,
    input  logic [NLANE-1:0] logic_ref,
    input  logic             ev_pop,
    output logic             ev_valid,
    output logic [((NCELL > NLANE ? $clog2(NCELL) : $clog2(NLANE)) + 2):0] ev_data,
    output logic             ev_overflow,
    output logic [CNTW-1:0]  cnt_storage,
    output logic [CNTW-1:0]  cnt_config,
    output logic [CNTW-1:0]  cnt_transient
);

    localparam int CW    = (NCELL > 1) ? $clog2(NCELL) : 1;
    localparam int LW    = (NLANE > 1) ? $clog2(NLANE) : 1;
    localparam int IW    = (CW > LW) ? CW : LW;
    localparam int REC_W = IW + 3;

    logic          seq_push;
    ev_type_t      seq_type;
    logic [CW-1:0] seq_idx;

    logic [NLANE-1:0] lane_pend, lane_grant, lane_cfg, lane_trn, lane_lost;
    ev_type_t         lane_ty [NLANE];

    logic [IW-1:0]    sel_idx;
    ev_type_t         sel_ty;
    logic             found;
    logic             push;
    logic [REC_W-1:0] rec;
    logic             fifo_full;
    logic [7:0]       inc_sto, inc_cfg, inc_trn;

    cell_seq #(
        .NCELL    (NCELL),
        .HOLD_CYC (HOLD_CYC),
        .CW       (CW)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .pat_sel     (pat_sel),
        .cell_q      (cell_q),
        .cell_d      (cell_d),
        .cell_strobe (cell_strobe),
        .log_push    (seq_push),
        .log_type    (seq_type),
        .log_idx     (seq_idx)
    );

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic_watch #(.LIMW(LIMW)) u_watch (
            .clk     (clk),
            .rst_n   (rst_n),
            .obs     (logic_obs[g]),
            .expv    (logic_ref[g]),
            .lim     (persist_lim),
            .grant   (lane_grant[g]),
            .pend    (lane_pend[g]),
            .ptype   (lane_ty[g]),
            .det_cfg (lane_cfg[g]),
            .det_trn (lane_trn[g]),
            .lost    (lane_lost[g])
        );
    end

    // R6: sequencer first, then lowest lane
    always_comb begin
        lane_grant = '0;
        sel_idx    = '0;
        sel_ty     = EV_TRN;
        found      = 1'b0;
        for (int i = 0; i < NLANE; i++) begin
            if (!seq_push && !found && lane_pend[i]) begin
                lane_grant[i] = 1'b1;
                sel_idx       = IW'(i);
                sel_ty        = lane_ty[i];
                found         = 1'b1;
            end
        end
        push = seq_push || found;
        if (seq_push) rec = {1'b0, seq_type, IW'(seq_idx)};
        else          rec = {1'b1, sel_ty, sel_idx};
    end

    event_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (rec),
        .pop   (ev_pop),
        .dout  (ev_data),
        .valid (ev_valid),
        .full  (fifo_full)
    );

    // detections per cycle
    always_comb begin
        inc_sto = {7'd0, seq_push && seq_type == EV_STO};
        inc_cfg = {7'd0, seq_push && seq_type == EV_CFG};
        inc_trn = 8'd0;
        for (int i = 0; i < NLANE; i++) begin
            inc_cfg = inc_cfg + {7'd0, lane_cfg[i]};
            inc_trn = inc_trn + {7'd0, lane_trn[i]};
        end
    end

    function automatic logic [CNTW-1:0] sat_add(input logic [CNTW-1:0] a, input logic [7:0] b);
        logic [CNTW:0] s;
        s = {1'b0, a} + (CNTW+1)'(b);
        return s[CNTW] ? {CNTW{1'b1}} : s[CNTW-1:0];
    endfunction

    // R7 / R8
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_storage   <= '0;
            cnt_config    <= '0;
            cnt_transient <= '0;
            ev_overflow   <= 1'b0;
        end else if (cnt_clr) begin
            cnt_storage   <= '0;
            cnt_config    <= '0;
            cnt_transient <= '0;
            ev_overflow   <= 1'b0;
        end else begin
            cnt_storage   <= sat_add(cnt_storage, inc_sto);
            cnt_config    <= sat_add(cnt_config, inc_cfg);
            cnt_transient <= sat_add(cnt_transient, inc_trn);
            if ((push && fifo_full) || (|lane_lost)) ev_overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/upset_chk.sv
`timescale 1ns/1ps
module upset_chk #(
    parameter int NCELL = 8,
    parameter int REC_W = 6,
    parameter int CNTW  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_clr,
    input logic [NCELL-1:0] cell_strobe,
    input logic             ev_valid,
    input logic             ev_pop,
    input logic [REC_W-1:0] ev_data,
    input logic             ev_overflow,
    input logic [CNTW-1:0]  cnt_storage,
    input logic [CNTW-1:0]  cnt_config,
    input logic [CNTW-1:0]  cnt_transient
);

    // R1
    strobe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cell_strobe) || (&cell_strobe));

    // R7
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_overflow && !cnt_clr) |=> ev_overflow);

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (cnt_storage == '0 && cnt_config == '0 && cnt_transient == '0 && !ev_overflow));

    // R8
    count_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> (cnt_storage >= $past(cnt_storage) && cnt_config >= $past(cnt_config)
                      && cnt_transient >= $past(cnt_transient)));

    // R6
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_pop) |=> (ev_valid && $stable(ev_data)));

    // R6
    type_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> (ev_data[REC_W-2 -: 2] != 2'b11));

endmodule

bind upset_tester upset_chk #(
    .NCELL (NCELL),
    .REC_W (REC_W),
    .CNTW  (CNTW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cnt_clr       (cnt_clr),
    .cell_strobe   (cell_strobe),
    .ev_valid      (ev_valid),
    .ev_pop        (ev_pop),
    .ev_data       (ev_data),
    .ev_overflow   (ev_overflow),
    .cnt_storage   (cnt_storage),
    .cnt_config    (cnt_config),
    .cnt_transient (cnt_transient)
);

// File: tb/sim_upset_tester.sv
`timescale 1ns/1ps
module sim_upset_tester;

    localparam int NC = 8;
    localparam int NL = 4;
    localparam int HOLD = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic [1:0]    pat_sel = 2'b00;
    logic [7:0]    persist_lim = 8'd8;
    logic          cnt_clr = 1'b0;
    logic [NC-1:0] cell_q, cell_d, cell_strobe;
    logic [NL-1:0] logic_obs = 4'b1010;
    logic [NL-1:0] logic_ref = 4'b1010;
    logic          ev_pop = 1'b0;
    logic          ev_valid;
    logic [5:0]    ev_data;
    logic          ev_overflow;
    logic [15:0]   cnt_storage, cnt_config, cnt_transient;

    // behavioural device under test: cells with flip and stuck-at hooks
    logic [NC-1:0] mem = '0;
    logic [NC-1:0] flip_mask = '0;
    logic [NC-1:0] stuck_en = '0;
    logic [NC-1:0] stuck_val = '0;

    always @(posedge clk) begin
        for (int i = 0; i < NC; i++) begin
            if (cell_strobe[i])    mem[i] <= cell_d[i];
            else if (flip_mask[i]) mem[i] <= ~mem[i];
        end
    end
    assign cell_q = (mem & ~stuck_en) | (stuck_val & stuck_en);

    always #10 clk = ~clk;

    upset_tester u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .run           (run),
        .pat_sel       (pat_sel),
        .persist_lim   (persist_lim),
        .cnt_clr       (cnt_clr),
        .cell_q        (cell_q),
        .cell_d        (cell_d),
        .cell_strobe   (cell_strobe),
        .logic_obs     (logic_obs),
        .logic_ref     (logic_ref),
        .ev_pop        (ev_pop),
        .ev_valid      (ev_valid),
        .ev_data       (ev_data),
        .ev_overflow   (ev_overflow),
        .cnt_storage   (cnt_storage),
        .cnt_config    (cnt_config),
        .cnt_transient (cnt_transient)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // reference model state
    int exp_sto = 0;
    int exp_cfg = 0;
    int exp_trn = 0;
    int exp_q[$];

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_counts(input string req);
        check({req, " storage count"}, int'(cnt_storage), exp_sto);
        check({req, " config count"}, int'(cnt_config), exp_cfg);
        check({req, " transient count"}, int'(cnt_transient), exp_trn);
    endtask

    task automatic pop_expect(input string req);
        int e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
        check({req, " record present"}, int'(ev_valid), 1);
        check({req, " record"}, int'(ev_data), e);
        ev_pop = 1'b1;
        tick(1);
        ev_pop = 1'b0;
    endtask

    task automatic wait_event();
        for (int k = 0; k < 400 && !ev_valid; k++) tick(1);
    endtask

    task automatic lane_err(input logic [NL-1:0] m, input int n);
        logic_obs = logic_ref ^ m;
        tick(n);
        logic_obs = logic_ref;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R9: reset state
        check_counts("R9");
        check("R9 fifo empty", int'(ev_valid), 0);
        check("R9 overflow", int'(ev_overflow), 0);
        check("R9 strobes", int'(cell_strobe), 0);

        // R1: all four (D,Q) combinations
        for (int p = 0; p < 4; p++) begin
            pat_sel = 2'(p);
            run = 1'b1;
            tick(3);
            check("R1 stored value", int'(cell_q), p[0] ? 8'hFF : 8'h00);
            check("R1 data input", int'(cell_d), p[1] ? 8'hFF : 8'h00);
            check("R1 strobes idle", int'(cell_strobe), 0);
            run = 1'b0;
            tick(80);
        end

        // R9: idle sequencer does not scan
        flip_mask[0] = 1'b1;
        tick(1);
        flip_mask[0] = 1'b0;
        tick(120);
        check("R9 no scan when idle", int'(ev_valid), 0);
        check_counts("R9");

        // R2: storage upset on cell 3, pattern D=0 Q=1
        pat_sel = 2'b01;
        run = 1'b1;
        tick(5);
        flip_mask[3] = 1'b1;
        tick(1);
        flip_mask[3] = 1'b0;
        exp_sto++;
        exp_q.push_back(6'b000011);
        wait_event();
        tick(2);
        check_counts("R2");
        check("R2 cell restored", int'(cell_q[3]), 1);
        pop_expect("R2");

        // R3: configuration upset on cell 5
        stuck_val[5] = 1'b0;
        stuck_en[5] = 1'b1;
        exp_cfg++;
        exp_q.push_back(6'b001101);
        wait_event();
        stuck_en[5] = 1'b0;
        tick(2);
        check_counts("R3");
        pop_expect("R3");
        run = 1'b0;
        tick(80);
        check("R3 no further events", int'(ev_valid), 0);

        // R4: transient on lane 2
        persist_lim = 8'd8;
        lane_err(4'b0100, 3);
        tick(3);
        exp_trn++;
        exp_q.push_back(6'b110010);
        check_counts("R4");
        pop_expect("R4");

        // R5: persistent on lane 1 with limit 8
        logic_obs = logic_ref ^ 4'b0010;
        tick(12);
        exp_cfg++;
        exp_q.push_back(6'b101001);
        check_counts("R5 while wrong");
        logic_obs = logic_ref;
        tick(3);
        check_counts("R5 after recovery");
        pop_expect("R5");
        check("R5 single record", int'(ev_valid), 0);

        // R5: limit boundary with limit 3
        persist_lim = 8'd3;
        lane_err(4'b0001, 3);
        tick(3);
        exp_cfg++;
        exp_q.push_back(6'b101000);
        lane_err(4'b0001, 2);
        tick(3);
        exp_trn++;
        exp_q.push_back(6'b110000);
        check_counts("R5 boundary");
        pop_expect("R5 boundary persistent");
        pop_expect("R5 boundary transient");

        // R6 / R7: fill past depth with lane 3 transients
        persist_lim = 8'd8;
        for (int n = 0; n < 20; n++) begin
            lane_err(4'b1000, 1);
            tick(1);
            exp_trn++;
            if (n < 16) exp_q.push_back(6'b110011);
        end
        tick(3);
        check_counts("R7 counts all detections");
        check("R7 overflow set", int'(ev_overflow), 1);
        for (int n = 0; n < 16; n++) pop_expect("R6 fifo order");
        check("R6 depth 16", int'(ev_valid), 0);
        check("R7 overflow sticky", int'(ev_overflow), 1);

        // R8: clear
        cnt_clr = 1'b1;
        tick(1);
        cnt_clr = 1'b0;
        exp_sto = 0; exp_cfg = 0; exp_trn = 0;
        check_counts("R8 clear");
        check("R7 overflow cleared", int'(ev_overflow), 0);

        // R8: saturation with all lanes toggling
        for (int n = 0; n < 16400; n++) begin
            lane_err(4'b1111, 1);
            tick(1);
        end
        tick(3);
        exp_trn = 65535;
        check_counts("R8 saturation");
        cnt_clr = 1'b1;
        tick(1);
        cnt_clr = 1'b0;
        exp_trn = 0;
        check_counts("R8 clear after saturation");

        finish_run();
    end

endmodule